// File: doc/BRIEF.md
# Line Transceiver Activation Controller

This block is a reduced layer-1 activation and deactivation controller for a line transceiver. It has three states: Reset, Deactivated and Activating. Its inputs are 4-bit command codes from a host port, line-side indications (info 0 present, wake-up seen), an active-low hardware reset, a clock-hold pin and a software override bit. It reports its state as a 4-bit indication code. It drives a 4-bit transmitter code and a clock-enable output.

The Reset state is also the pending-deactivation state. It ignores activation requests until the host sends a deactivate command. In Deactivated, the clocks are shut down once info 0 has been received for a configurable number of cycles, unless the clock-hold pin is high. An activation request from the host or a line wake-up moves the block to Activating. That raises clock enable at once and cancels any countdown. When software override is set, the state machine is frozen and the transmitter code follows a host register directly.

Top module: `link_act_fsm`

## Requirements
- R1: While `rstN` is low, `ciInd` is 0001, `txCode` is 0000 and `clkEn` is 1.
- R2: A valid command code 0001 (reset) moves the block to the Reset state (`ciInd` 0001) at the next clock edge, from any state.
- R3: In Reset, the activate command 0100 and `rxWake` are ignored. In every state, command codes other than 0001, 0100 and 1111 leave the state unchanged.
- R4: In Reset, a valid command 1111 (deactivate) moves the block to Deactivated (`ciInd` 1111, `txCode` 0000) at the next edge.
- R5: In Deactivated, a valid command 0100 or a high `rxWake` moves the block to Activating (`ciInd` 0100, `txCode` 0001) at the next edge.
- R6: In Activating, a high `rxInfo0` returns the block to Reset. Otherwise a valid command 1111 returns it to Deactivated.
- R7: In Deactivated with `rxInfo0` high and `clkHold` low, `clkEn` goes low after TIMER_TICKS consecutive cycles with `rxInfo0` high, counted from entry, and stays low. A low `rxInfo0` restarts the count.
- R8: While `clkHold` is high, `clkEn` is 1.
- R9: Leaving Deactivated for Activating sets `clkEn` to 1 in the cycle after the edge, even after a completed shutdown.
- R10: While `swOverride` is high, the state (and so `ciInd`) holds regardless of commands and line indications, and `txCode` equals `hostTxCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low hardware reset, asynchronous |
| ciValid | input | 1 | Command strobe, one cycle per command |
| ciCmd | input | 4 | Command code from host |
| rxInfo0 | input | 1 | Line receiver sees info 0 |
| rxWake | input | 1 | Line receiver sees wake-up signal |
| clkHold | input | 1 | High keeps clocks running |
| swOverride | input | 1 | Freezes state machine, host drives transmitter |
| hostTxCode | input | 4 | Host transmitter code used under override |
| ciInd | output | 4 | Indication code for current state |
| txCode | output | 4 | Transmitter code |
| clkEn | output | 1 | Clock enable |

## Verification
The bench runs the shutdown countdown to its exact terminal cycle. A timer that is off by one would drop `clkEn` a cycle early or late. A design that did not restart the count when info 0 dropped would shut down too soon. Activation requests and wake-ups are applied in Reset, where a design that honoured them would leave Reset without a deactivate command. The bench also drives commands and info 0 under software override, and raises the clock-hold pin while the clock is stopped. A design that leaked state changes through the override, or gated the clock despite the hold pin, shows a wrong indication or a low enable.

// File: rtl/link_act_pkg.sv
package link_act_pkg;

  localparam logic [3:0] CMD_RES = 4'b0001;
  localparam logic [3:0] CMD_ACT = 4'b0100;
  localparam logic [3:0] CMD_DI  = 4'b1111;

  localparam logic [3:0] IND_RST   = 4'b0001;
  localparam logic [3:0] IND_DEACT = 4'b1111;
  localparam logic [3:0] IND_ACT   = 4'b0100;

  localparam logic [3:0] TX_IDLE = 4'b0000;
  localparam logic [3:0] TX_ACT  = 4'b0001;

  typedef enum logic [1:0] {
    ST_RST   = 2'd0,
    ST_DEACT = 2'd1,
    ST_ACT   = 2'd2
  } actState_t;

  typedef struct packed {
    logic       inDeact;
    logic       countEn;
    logic [3:0] indCode;
    logic [3:0] txState;
  } ctlStrobe_t;

endpackage

// File: rtl/link_act_ctrl.sv
module link_act_ctrl
  import link_act_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ciValid,
  input  logic [3:0] ciCmd,
  input  logic       rxInfo0,
  input  logic       rxWake,
  input  logic       swOverride,
  output ctlStrobe_t strobe
);

  actState_t state, nextState;
  logic cmdRes, cmdAct, cmdDi;

  assign cmdRes = ciValid && (ciCmd == CMD_RES);
  assign cmdAct = ciValid && (ciCmd == CMD_ACT);
  assign cmdDi  = ciValid && (ciCmd == CMD_DI);

  always_comb begin
    nextState = state;
    if (!swOverride) begin
      if (cmdRes) begin
        nextState = ST_RST;
      end else begin
        case (state)
          ST_RST:   if (cmdDi) nextState = ST_DEACT;
          ST_DEACT: if (cmdAct || rxWake) nextState = ST_ACT;
          ST_ACT: begin
            if (rxInfo0)    nextState = ST_RST;
            else if (cmdDi) nextState = ST_DEACT;
          end
          default: nextState = ST_RST;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RST;
    else       state <= nextState;
  end

  always_comb begin
    strobe.inDeact = (state == ST_DEACT);
    strobe.countEn = (state == ST_DEACT) && rxInfo0;
    case (state)
      ST_DEACT: begin strobe.indCode = IND_DEACT; strobe.txState = TX_IDLE; end
      ST_ACT:   begin strobe.indCode = IND_ACT;   strobe.txState = TX_ACT;  end
      default:  begin strobe.indCode = IND_RST;   strobe.txState = TX_IDLE; end
    endcase
  end

endmodule

// File: rtl/link_act_dp.sv
module link_act_dp
  import link_act_pkg::*;
#(
  parameter int TIMER_TICKS = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       clkHold,
  input  logic       swOverride,
  input  logic [3:0] hostTxCode,
  output logic [3:0] ciInd,
  output logic [3:0] txCode,
  output logic       clkEn
);

  localparam int CNT_W = $clog2(TIMER_TICKS + 1);
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TIMER_TICKS);

  logic [CNT_W-1:0] holdCnt;
  logic             expired;

  assign expired = (holdCnt == TERM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (!strobe.countEn) holdCnt <= '0;
    else if (!expired)        holdCnt <= holdCnt + 1'b1;
  end

  assign clkEn  = clkHold || !(strobe.inDeact && expired);
  assign ciInd  = strobe.indCode;
  assign txCode = swOverride ? hostTxCode : strobe.txState;

endmodule

// File: rtl/link_act_fsm.sv
module link_act_fsm
  import link_act_pkg::*;
#(
  parameter int TIMER_TICKS = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ciValid,
  input  logic [3:0] ciCmd,
  input  logic       rxInfo0,
  input  logic       rxWake,
  input  logic       clkHold,
  input  logic       swOverride,
  input  logic [3:0] hostTxCode,
  output logic [3:0] ciInd,
  output logic [3:0] txCode,
  output logic       clkEn
);

  ctlStrobe_t strobe;

  link_act_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ciValid    (ciValid),
    .ciCmd      (ciCmd),
    .rxInfo0    (rxInfo0),
    .rxWake     (rxWake),
    .swOverride (swOverride),
    .strobe     (strobe)
  );

  link_act_dp #(.TIMER_TICKS(TIMER_TICKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .clkHold    (clkHold),
    .swOverride (swOverride),
    .hostTxCode (hostTxCode),
    .ciInd      (ciInd),
    .txCode     (txCode),
    .clkEn      (clkEn)
  );

endmodule

// File: rtl/link_act_chk.sv
module link_act_chk
  import link_act_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       ciValid,
  input logic [3:0] ciCmd,
  input logic       rxInfo0,
  input logic       rxWake,
  input logic       clkHold,
  input logic       swOverride,
  input logic [3:0] hostTxCode,
  input logic [3:0] ciInd,
  input logic [3:0] txCode,
  input logic       clkEn
);

  logic resCmd;
  assign resCmd = ciValid && (ciCmd == CMD_RES);

  p_res_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resCmd && !swOverride) |=> (ciInd == IND_RST));

  p_rst_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((ciInd == IND_RST) && !(ciValid && ciCmd == CMD_DI)) |=> (ciInd == IND_RST));

  p_di_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((ciInd == IND_RST) && ciValid && ciCmd == CMD_DI && !swOverride) |=> (ciInd == IND_DEACT));

  p_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((ciInd == IND_DEACT) && rxWake && !resCmd && !swOverride) |=> (ciInd == IND_ACT));

  p_info0_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((ciInd == IND_ACT) && rxInfo0 && !swOverride) |=> (ciInd == IND_RST));

  p_hold_clk_r8: assert property (@(posedge clk) disable iff (!rstN)
    clkHold |-> clkEn);

  p_act_clk_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ciInd == IND_ACT) |-> clkEn);

  p_ovr_tx_r10: assert property (@(posedge clk) disable iff (!rstN)
    swOverride |-> (txCode == hostTxCode));

  p_ovr_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    swOverride |=> $stable(ciInd));

endmodule

bind link_act_fsm link_act_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ciValid    (ciValid),
  .ciCmd      (ciCmd),
  .rxInfo0    (rxInfo0),
  .rxWake     (rxWake),
  .clkHold    (clkHold),
  .swOverride (swOverride),
  .hostTxCode (hostTxCode),
  .ciInd      (ciInd),
  .txCode     (txCode),
  .clkEn      (clkEn)
);

// File: tb/link_act_fsm_bench.sv
module link_act_fsm_bench;

  localparam int TICKS = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ciValid = 1'b0;
  logic [3:0] ciCmd = 4'b0000;
  logic       rxInfo0 = 1'b0, rxWake = 1'b0, clkHold = 1'b0, swOverride = 1'b0;
  logic [3:0] hostTxCode = 4'b0000;
  logic [3:0] ciInd, txCode;
  logic       clkEn;

  logic       nInfo0 = 1'b0, nWake = 1'b0, nHold = 1'b0, nOvr = 1'b0;
  logic [3:0] nHost = 4'b0000;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] ind;
    logic [3:0] tx;
    logic       ce;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  link_act_fsm #(.TIMER_TICKS(TICKS)) u_link_act_fsm (
    .clk(clk), .rstN(rstN), .ciValid(ciValid), .ciCmd(ciCmd),
    .rxInfo0(rxInfo0), .rxWake(rxWake), .clkHold(clkHold),
    .swOverride(swOverride), .hostTxCode(hostTxCode),
    .ciInd(ciInd), .txCode(txCode), .clkEn(clkEn)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (ciInd !== e.ind || txCode !== e.tx || clkEn !== e.ce) begin
      errors++;
      $display("FAIL %s: got ind=%b tx=%b clkEn=%b, expected ind=%b tx=%b clkEn=%b",
               e.tag, ciInd, txCode, clkEn, e.ind, e.tx, e.ce);
    end
  endtask

  // Monitor: compares each expectation after the edge that follows its push.
  always @(posedge clk) begin
    #3;
    if (sbq.size() > 0) compare(sbq.pop_front());
  end

  // Driver: one cycle of stimulus plus the outputs expected after the next edge.
  task automatic cyc(input logic v, input logic [3:0] c,
                     input logic [3:0] ind, input logic [3:0] tx, input logic ce,
                     input string tag);
    exp_t e;
    @(negedge clk);
    ciValid = v; ciCmd = c;
    rxInfo0 = nInfo0; rxWake = nWake; clkHold = nHold;
    swOverride = nOvr; hostTxCode = nHost;
    e.ind = ind; e.tx = tx; e.ce = ce; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic checkNow(input logic [3:0] ind, input logic [3:0] tx,
                          input logic ce, input string tag);
    exp_t e;
    e.ind = ind; e.tx = tx; e.ce = ce; e.tag = tag;
    compare(e);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    finishRun();
  end

  initial begin
    #22;
    checkNow(4'b0001, 4'b0000, 1'b1, "R1 reset state");
    @(negedge clk); rstN = 1'b1;

    // R3: activation ignored in Reset
    cyc(1, 4'b0100, 4'b0001, 4'b0000, 1, "R3 act cmd ignored in reset");
    nWake = 1;
    cyc(0, 4'b0000, 4'b0001, 4'b0000, 1, "R3 wake ignored in reset");
    nWake = 0;
    cyc(1, 4'b0101, 4'b0001, 4'b0000, 1, "R3 unused code in reset");
    cyc(1, 4'b1111, 4'b1111, 4'b0000, 1, "R4 deactivate from reset");
    cyc(1, 4'b0101, 4'b1111, 4'b0000, 1, "R3 unused code in deactivated");
    cyc(1, 4'b0100, 4'b0100, 4'b0001, 1, "R5 act cmd from deactivated");
    cyc(1, 4'b1111, 4'b1111, 4'b0000, 1, "R6 deactivate from activating");
    nWake = 1;
    cyc(0, 4'b0000, 4'b0100, 4'b0001, 1, "R5 wake from deactivated");
    nWake = 0; nInfo0 = 1;
    cyc(0, 4'b0000, 4'b0001, 4'b0000, 1, "R6 info0 in activating");

    // R7: countdown with info 0 present
    cyc(1, 4'b1111, 4'b1111, 4'b0000, 1, "R4 deactivate with info0");
    for (int i = 1; i < TICKS; i++)
      cyc(0, 4'b0000, 4'b1111, 4'b0000, 1, "R7 clock still on before terminal");
    cyc(0, 4'b0000, 4'b1111, 4'b0000, 0, "R7 clock off at terminal");
    cyc(0, 4'b0000, 4'b1111, 4'b0000, 0, "R7 clock stays off");
    nHold = 1;
    cyc(0, 4'b0000, 4'b1111, 4'b0000, 1, "R8 hold pin forces clock on");
    nHold = 0;
    cyc(0, 4'b0000, 4'b1111, 4'b0000, 0, "R7 clock off after hold released");

    // R7: info 0 gap restarts the count
    nInfo0 = 0;
    cyc(0, 4'b0000, 4'b1111, 4'b0000, 1, "R7 info0 gone restores clock");
    nInfo0 = 1;
    for (int i = 1; i < 4; i++)
      cyc(0, 4'b0000, 4'b1111, 4'b0000, 1, "R7 partial count");
    nInfo0 = 0;
    cyc(0, 4'b0000, 4'b1111, 4'b0000, 1, "R7 gap clears count");
    nInfo0 = 1;
    for (int i = 1; i < TICKS; i++)
      cyc(0, 4'b0000, 4'b1111, 4'b0000, 1, "R7 restarted count no early stop");
    cyc(0, 4'b0000, 4'b1111, 4'b0000, 0, "R7 restarted count terminal");

    nInfo0 = 0;
    cyc(1, 4'b0100, 4'b0100, 4'b0001, 1, "R9 activation after shutdown");

    // R10: override freezes state, host drives transmitter
    nOvr = 1; nHost = 4'b1010;
    cyc(1, 4'b0001, 4'b0100, 4'b1010, 1, "R10 reset cmd ignored under override");
    nInfo0 = 1;
    cyc(0, 4'b0000, 4'b0100, 4'b1010, 1, "R10 info0 ignored under override");
    nHost = 4'b0110;
    cyc(1, 4'b1111, 4'b0100, 4'b0110, 1, "R10 tx follows host");
    nOvr = 0; nInfo0 = 0;
    cyc(1, 4'b0001, 4'b0001, 4'b0000, 1, "R2 reset cmd from activating");

    cyc(1, 4'b1111, 4'b1111, 4'b0000, 1, "R4 deactivate again");
    cyc(1, 4'b0001, 4'b0001, 4'b0000, 1, "R2 reset cmd from deactivated");
    cyc(1, 4'b1111, 4'b1111, 4'b0000, 1, "R4 deactivate again");
    cyc(1, 4'b0100, 4'b0100, 4'b0001, 1, "R5 activate again");
    cyc(0, 4'b0000, 4'b0100, 4'b0001, 1, "R5 activating held");

    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkNow(4'b0001, 4'b0000, 1'b1, "R1 hardware reset from activating");
    @(negedge clk); rstN = 1'b1;
    cyc(0, 4'b0000, 4'b0001, 4'b0000, 1, "R1 reset state held after release");

    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule